// File: doc/BRIEF.md
# Multi-Cycle 32-bit Integer Core

This block is a small sequential processor for the base 32-bit integer instruction set. It runs each instruction as a short sequence of states: fetch one word over a word-addressed memory port, decode it, execute it, and write back where the instruction needs it. It supports the register and immediate arithmetic groups, the six conditional branches, the two jumps, the two upper-immediate forms, word load, word store and the environment call. State consists of a 32-entry register file and a program counter. A status pin reports a permanent stop.

Errors never trap. A bad program counter or an opcode outside the supported set stops the core until reset. A data access that is misaligned, out of range, or not word-sized is dropped, and execution goes on at the next instruction. An environment call with funct3 = 0 hands a service number and an argument to an external console over a valid/ready request. The core waits in that state until the console accepts.

Memory timing: `mem_addr` is driven combinationally, and the memory must return `mem_rdata` for that word one clock later (a registered read). A write is performed at the clock edge where `mem_we` is high.

Top module: `rvmc_core`

## Requirements
- R1: After reset the program counter is 0, every register reads 0, `halted` is low and no console request is raised.
- R2: Before each fetch the core stops permanently if the program counter is not a multiple of 4, or if its word index (pc >> 2) is at least MEM_WORDS. `pc_o` keeps the offending value.
- R3: Opcode field bits [6:0] outside {0x33, 0x13, 0x63, 0x6F, 0x67, 0x37, 0x17, 0x03, 0x23, 0x73} stop the core. Once stopped, `halted` stays high and `pc_o` stays fixed until reset.
- R4: Opcode 0x33 selects by funct3 (bits 14:12): 0 add/sub (funct7 bits 31:25 = 0x00 / 0x20), 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 logical/arithmetic right shift (funct7 0x00 / 0x20), 6 or, 7 and. Shift amounts use only the low 5 bits. An unlisted funct7 for funct3 0 or 5 writes nothing. Every form advances pc by 4.
- R5: Opcode 0x13 does the same operations with the sign-extended 12-bit immediate from bits 31:20. Unsigned compares treat the extended immediate as unsigned. Right shifts pick arithmetic when bits 31:25 are 0x20, logical when they are 0x00, and write nothing otherwise.
- R6: Opcode 0x63 branches (funct3 0 eq, 1 ne, 4 signed lt, 5 signed ge, 6 unsigned lt, 7 unsigned ge) go to the branch pc plus the 13-bit scattered offset, sign-extended from bit 12. Not taken, or funct3 2/3, gives pc + 4.
- R7: Opcode 0x6F adds the 21-bit offset (sign-extended from bit 20) to pc. Opcode 0x67 jumps to (rs1 + sign-extended imm) with bit 0 cleared. Both write the old pc + 4 to rd.
- R8: Opcode 0x37 writes the upper 20 immediate bits with 12 zero bits to rd. Opcode 0x17 writes that value plus the instruction's own pc.
- R9: Loads (0x03) and stores (0x23) act only when funct3 = 2 and the byte address rs1 + imm is 4-aligned with word index below MEM_WORDS. Otherwise they change neither registers nor memory. pc always advances by 4.
- R10: Register x0 always reads zero, whatever is written to it.
- R11: Opcode 0x73 with funct3 = 0 raises `ecall_valid`, with `ecall_svc` = x17 and `ecall_arg` = x10. Both values and pc stay stable until `ecall_ready` is sampled high at a clock edge, and then pc advances by 4. With any other funct3 the instruction raises no request and advances pc by 4.
- R12: While `step_en` is low between instructions, the core fetches nothing and its pc does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Permits the next instruction to start |
| mem_addr | output | $clog2(MEM_WORDS) | Word index for fetch, load or store |
| mem_we | output | 1 | Word write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_addr` |
| ecall_valid | output | 1 | Console request pending |
| ecall_ready | input | 1 | Console accepts the request this cycle |
| ecall_svc | output | 32 | Service number (x17) |
| ecall_arg | output | 32 | Argument (x10) |
| pc_o | output | 32 | Current program counter |
| halted | output | 1 | Core has stopped permanently |

## Verification
The bench builds the core with MEM_WORDS = 64. Byte address 256 then sits exactly one word past the end, so out-of-range fetches and data accesses are reachable with short immediates. A word-index comparison that wrapped to the port width would alias such accesses onto word 0, and the bench would see it. The register file keeps its default 32 entries, so x10 and x17 are the real call registers. Backward jumps and branches from address 0 wrap to the top of the address space and exercise sign extension together with the range check.

// File: rtl/rvmc_pkg.sv
package rvmc_pkg;
  localparam int XW = 32;

  localparam logic [6:0] OP_REG   = 7'h33;
  localparam logic [6:0] OP_IMM   = 7'h13;
  localparam logic [6:0] OP_BR    = 7'h63;
  localparam logic [6:0] OP_JAL   = 7'h6F;
  localparam logic [6:0] OP_JALR  = 7'h67;
  localparam logic [6:0] OP_LUI   = 7'h37;
  localparam logic [6:0] OP_AUIPC = 7'h17;
  localparam logic [6:0] OP_LOAD  = 7'h03;
  localparam logic [6:0] OP_STORE = 7'h23;
  localparam logic [6:0] OP_SYS   = 7'h73;

  localparam logic [4:0] SVC_REG = 5'd17;
  localparam logic [4:0] ARG_REG = 5'd10;
  localparam logic [2:0] F3_WORD = 3'd2;

  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_SLL, A_SLT, A_SLTU, A_XOR, A_SRL, A_SRA, A_OR, A_AND, A_PASSB
  } alu_op_e;

  typedef enum logic [2:0] {
    K_ALU, K_BR, K_JAL, K_JALR, K_LD, K_ST, K_SYS, K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LATCH, S_EXEC, S_LOAD, S_CALL, S_HALT
  } state_e;

  typedef struct packed {
    kind_e          kind;
    alu_op_e        op;
    logic           use_imm;
    logic           use_pc;
    logic           wr;
    logic [4:0]     rd;
    logic [4:0]     rs1;
    logic [4:0]     rs2;
    logic [2:0]     f3;
    logic [XW-1:0]  imm;
  } ctrl_t;
endpackage

// File: rtl/rvmc_decode.sv
module rvmc_decode
  import rvmc_pkg::*;
(
  input  logic [XW-1:0] ir,
  output ctrl_t         ctrl
);
  logic [XW-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
  logic [6:0]    f7;

  assign f7    = ir[31:25];
  assign imm_i = {{20{ir[31]}}, ir[31:20]};
  assign imm_s = {{20{ir[31]}}, ir[31:25], ir[11:7]};
  assign imm_b = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
  assign imm_u = {ir[31:12], 12'h000};
  assign imm_j = {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};

  always_comb begin
    ctrl         = '0;
    ctrl.kind    = K_BAD;
    ctrl.op      = A_ADD;
    ctrl.rd      = ir[11:7];
    ctrl.rs1     = ir[19:15];
    ctrl.rs2     = ir[24:20];
    ctrl.f3      = ir[14:12];
    case (ir[6:0])
      OP_REG, OP_IMM: begin
        ctrl.kind    = K_ALU;
        ctrl.wr      = 1'b1;
        ctrl.use_imm = (ir[6:0] == OP_IMM);
        ctrl.imm     = imm_i;
        case (ir[14:12])
          3'd0: begin
            if (ir[6:0] == OP_IMM)   ctrl.op = A_ADD;
            else if (f7 == 7'h00)    ctrl.op = A_ADD;
            else if (f7 == 7'h20)    ctrl.op = A_SUB;
            else                     ctrl.wr = 1'b0;
          end
          3'd1: ctrl.op = A_SLL;
          3'd2: ctrl.op = A_SLT;
          3'd3: ctrl.op = A_SLTU;
          3'd4: ctrl.op = A_XOR;
          3'd5: begin
            if (f7 == 7'h00)      ctrl.op = A_SRL;
            else if (f7 == 7'h20) ctrl.op = A_SRA;
            else                  ctrl.wr = 1'b0;
          end
          3'd6: ctrl.op = A_OR;
          default: ctrl.op = A_AND;
        endcase
      end
      OP_BR: begin
        ctrl.kind = K_BR;
        ctrl.imm  = imm_b;
      end
      OP_JAL: begin
        ctrl.kind = K_JAL;
        ctrl.imm  = imm_j;
      end
      OP_JALR: begin
        ctrl.kind = K_JALR;
        ctrl.imm  = imm_i;
      end
      OP_LUI: begin
        ctrl.kind    = K_ALU;
        ctrl.op      = A_PASSB;
        ctrl.use_imm = 1'b1;
        ctrl.wr      = 1'b1;
        ctrl.imm     = imm_u;
      end
      OP_AUIPC: begin
        ctrl.kind    = K_ALU;
        ctrl.op      = A_ADD;
        ctrl.use_imm = 1'b1;
        ctrl.use_pc  = 1'b1;
        ctrl.wr      = 1'b1;
        ctrl.imm     = imm_u;
      end
      OP_LOAD: begin
        ctrl.kind = K_LD;
        ctrl.imm  = imm_i;
      end
      OP_STORE: begin
        ctrl.kind = K_ST;
        ctrl.imm  = imm_s;
      end
      OP_SYS: ctrl.kind = K_SYS;
      default: ctrl.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/rvmc_alu.sv
module rvmc_alu
  import rvmc_pkg::*;
(
  input  alu_op_e       op,
  input  logic [2:0]    f3,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y,
  output logic          take
);
  localparam int SHW = $clog2(XW);

  logic [SHW-1:0] sh;
  logic           lt_s, lt_u, eq;

  assign sh   = b[SHW-1:0];
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;
  assign eq   = (a == b);

  always_comb begin
    case (op)
      A_ADD:   y = a + b;
      A_SUB:   y = a - b;
      A_SLL:   y = a << sh;
      A_SLT:   y = {{(XW-1){1'b0}}, lt_s};
      A_SLTU:  y = {{(XW-1){1'b0}}, lt_u};
      A_XOR:   y = a ^ b;
      A_SRL:   y = a >> sh;
      A_SRA:   y = $unsigned($signed(a) >>> sh);
      A_OR:    y = a | b;
      A_AND:   y = a & b;
      default: y = b;
    endcase
  end

  always_comb begin
    case (f3)
      3'd0:    take = eq;
      3'd1:    take = !eq;
      3'd4:    take = lt_s;
      3'd5:    take = !lt_s;
      3'd6:    take = lt_u;
      3'd7:    take = !lt_u;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvmc_regfile.sv
module rvmc_regfile
  import rvmc_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [XW-1:0]           rd1,
  output logic [XW-1:0]           rd2
);
  localparam int RAW = $clog2(NREG);

  logic [NREG*XW-1:0] flat;

  assign flat[XW-1:0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic [XW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)                            r <= '0;
      else if (we && waddr == RAW'(g))       r <= wdata;
    end
    assign flat[g*XW +: XW] = r;

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == RAW'(g)) |=> (r == $past(wdata)));
  end

  assign rd1 = flat[XW*ra1 +: XW];
  assign rd2 = flat[XW*ra2 +: XW];
endmodule

// File: rtl/rvmc_core.sv
module rvmc_core
  import rvmc_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  parameter int NREG      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step_en,
  output logic [$clog2(MEM_WORDS)-1:0]  mem_addr,
  output logic                          mem_we,
  output logic [31:0]                   mem_wdata,
  input  logic [31:0]                   mem_rdata,
  output logic                          ecall_valid,
  input  logic                          ecall_ready,
  output logic [31:0]                   ecall_svc,
  output logic [31:0]                   ecall_arg,
  output logic [31:0]                   pc_o,
  output logic                          halted
);
  localparam int AW  = $clog2(MEM_WORDS);
  localparam int RAW = $clog2(NREG);
  localparam logic [XW-3:0] WORD_LIMIT = (XW-2)'(MEM_WORDS);

  state_e        state, state_n;
  logic [XW-1:0] pc, pc_n, ir;
  ctrl_t         ctl;
  logic [XW-1:0] rs1v, rs2v, alu_a, alu_b, alu_y, ea, link, wb_data;
  logic [RAW-1:0] ra1, ra2;
  logic          take, pc_ok, ea_ok, wb_we;

  rvmc_decode u_dec (.ir(ir), .ctrl(ctl));

  // during a console call the read ports are steered to the call registers
  assign ra1 = (state == S_CALL) ? RAW'(SVC_REG) : RAW'(ctl.rs1);
  assign ra2 = (state == S_CALL) ? RAW'(ARG_REG) : RAW'(ctl.rs2);

  rvmc_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_we), .waddr(RAW'(ctl.rd)), .wdata(wb_data),
    .ra1(ra1), .ra2(ra2), .rd1(rs1v), .rd2(rs2v)
  );

  assign alu_a = ctl.use_pc  ? pc      : rs1v;
  assign alu_b = ctl.use_imm ? ctl.imm : rs2v;

  rvmc_alu u_alu (.op(ctl.op), .f3(ctl.f3), .a(alu_a), .b(alu_b), .y(alu_y), .take(take));

  assign ea    = rs1v + ctl.imm;
  assign link  = pc + 32'd4;
  assign pc_ok = (pc[1:0] == 2'b00) && (pc[XW-1:2] < WORD_LIMIT);
  assign ea_ok = (ea[1:0] == 2'b00) && (ea[XW-1:2] < WORD_LIMIT);

  always_comb begin
    wb_we   = 1'b0;
    wb_data = alu_y;
    if (state == S_EXEC) begin
      if (ctl.kind == K_ALU && ctl.wr) wb_we = 1'b1;
      if (ctl.kind == K_JAL || ctl.kind == K_JALR) begin
        wb_we   = 1'b1;
        wb_data = link;
      end
    end else if (state == S_LOAD) begin
      wb_we   = 1'b1;
      wb_data = mem_rdata;
    end
  end

  always_comb begin
    state_n = state;
    pc_n    = pc;
    case (state)
      S_IDLE:  if (step_en) state_n = S_FETCH;
      S_FETCH: state_n = pc_ok ? S_LATCH : S_HALT;
      S_LATCH: state_n = S_EXEC;
      S_EXEC: begin
        state_n = S_IDLE;
        pc_n    = link;
        case (ctl.kind)
          K_BR:   if (take) pc_n = pc + ctl.imm;
          K_JAL:  pc_n = pc + ctl.imm;
          K_JALR: pc_n = {ea[XW-1:1], 1'b0};
          K_LD: if (ctl.f3 == F3_WORD && ea_ok) begin
            state_n = S_LOAD;
            pc_n    = pc;
          end
          K_SYS: if (ctl.f3 == 3'd0) begin
            state_n = S_CALL;
            pc_n    = pc;
          end
          K_BAD: begin
            state_n = S_HALT;
            pc_n    = pc;
          end
          default: ;
        endcase
      end
      S_LOAD: begin
        state_n = S_IDLE;
        pc_n    = link;
      end
      S_CALL: if (ecall_ready) begin
        state_n = S_IDLE;
        pc_n    = link;
      end
      S_HALT:  ;
      default: state_n = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc    <= '0;
      ir    <= '0;
    end else begin
      state <= state_n;
      pc    <= pc_n;
      if (state == S_LATCH) ir <= mem_rdata;
    end
  end

  assign mem_addr    = (state == S_EXEC) ? ea[AW+1:2] : pc[AW+1:2];
  assign mem_we      = (state == S_EXEC) && (ctl.kind == K_ST) && (ctl.f3 == F3_WORD) && ea_ok;
  assign mem_wdata   = rs2v;
  assign ecall_valid = (state == S_CALL);
  assign ecall_svc   = rs1v;
  assign ecall_arg   = rs2v;
  assign pc_o        = pc;
  assign halted      = (state == S_HALT);

  assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_o)));

  assert_fetch_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && pc[1:0] != 2'b00) |=> halted);

  assert_call_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ecall_valid && !ecall_ready) |=>
      (ecall_valid && $stable(ecall_svc) && $stable(ecall_arg) && $stable(pc_o)));

  assert_idle_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !step_en) |=> (state == S_IDLE && $stable(pc_o)));

  assert_alu_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && ctl.kind == K_ALU) |=> (pc_o == $past(pc_o) + 32'd4));

  assert_store_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!halted && !ecall_valid && mem_addr == ea[AW+1:2]));
endmodule

// File: tb/sim_rvmc_core.sv
module sim_rvmc_core;
  localparam int MW = 64;
  localparam int AW = $clog2(MW);
  localparam int NV = 29;

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [2:0] f3);
    return {f7, 5'd2, 5'd1, f3, 5'd3, 7'h33};
  endfunction
  function automatic logic [31:0] e_i(input logic [6:0] op, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [4:0] rs1,
                                      input logic [11:0] imm);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] e_s(input logic [4:0] rs1, input logic [4:0] rs2,
                                      input logic [11:0] imm);
    return {imm[11:5], rs2, rs1, 3'd2, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] e_b(input logic [2:0] f3, input logic [4:0] rs1,
                                      input logic [4:0] rs2, input logic [12:0] off);
    return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], 7'h63};
  endfunction
  function automatic logic [31:0] e_j(input logic [4:0] rd, input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'h6F};
  endfunction
  function automatic logic [31:0] e_u(input logic [6:0] op, input logic [4:0] rd,
                                      input logic [19:0] imm);
    return {imm, rd, op};
  endfunction
  function automatic logic [167:0] v(input logic [7:0] req, input logic [31:0] ins,
                                     input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] e3, input logic [31:0] e4);
    return {req, ins, a, b, e3, e4};
  endfunction

  // each vector: requirement, instruction at word 5 (rd=x3, rs1=x1, rs2=x2),
  // x1, x2, expected x3 (starts at 0x55), expected x4 (1 unless word 6 was skipped)
  localparam logic [167:0] VEC [NV] = '{
    v(4, e_r(7'h00, 3'd0), 32'h7FFFFFFF, 32'h1,        32'h80000000, 1), // R4 add wraps
    v(4, e_r(7'h20, 3'd0), 32'd5,        32'd7,        32'hFFFFFFFE, 1), // R4 sub
    v(4, e_r(7'h00, 3'd1), 32'd1,        32'd33,       32'd2,        1), // R4 shift masks
    v(4, e_r(7'h00, 3'd2), 32'hFFFFFFFF, 32'd1,        32'd1,        1),
    v(4, e_r(7'h00, 3'd3), 32'hFFFFFFFF, 32'd1,        32'd0,        1),
    v(4, e_r(7'h00, 3'd4), 32'h0000F0F0, 32'h0000FF00, 32'h00000FF0, 1),
    v(4, e_r(7'h00, 3'd5), 32'h80000000, 32'd4,        32'h08000000, 1),
    v(4, e_r(7'h20, 3'd5), 32'h80000000, 32'd4,        32'hF8000000, 1),
    v(4, e_r(7'h00, 3'd6), 32'h00001200, 32'h00000034, 32'h00001234, 1),
    v(4, e_r(7'h00, 3'd7), 32'h0000FF0F, 32'h00000FF0, 32'h00000F00, 1),
    v(4, e_r(7'h01, 3'd0), 32'd9,        32'd9,        32'h55,       1), // R4 bad funct7
    v(5, e_i(7'h13, 3'd0, 5'd3, 5'd1, 12'hFFF), 32'd0, 32'd0, 32'hFFFFFFFF, 1), // R5
    v(5, e_i(7'h13, 3'd3, 5'd3, 5'd1, 12'hFFF), 32'd5, 32'd0, 32'd1,        1),
    v(5, e_i(7'h13, 3'd5, 5'd3, 5'd1, 12'h41F), 32'h80000000, 32'd0, 32'hFFFFFFFF, 1),
    v(5, e_i(7'h13, 3'd4, 5'd3, 5'd1, 12'h800), 32'd0, 32'd0, 32'hFFFFF800, 1),
    v(6, e_b(3'd0, 5'd1, 5'd2, 13'd8), 32'd3,        32'd3, 32'h55, 0), // R6 taken
    v(6, e_b(3'd1, 5'd1, 5'd2, 13'd8), 32'd3,        32'd3, 32'h55, 1),
    v(6, e_b(3'd4, 5'd1, 5'd2, 13'd8), 32'hFFFFFFFF, 32'd1, 32'h55, 0),
    v(6, e_b(3'd5, 5'd1, 5'd2, 13'd8), 32'hFFFFFFFF, 32'd1, 32'h55, 1),
    v(6, e_b(3'd6, 5'd1, 5'd2, 13'd8), 32'hFFFFFFFF, 32'd1, 32'h55, 1),
    v(6, e_b(3'd7, 5'd1, 5'd2, 13'd8), 32'hFFFFFFFF, 32'd1, 32'h55, 0),
    v(7, e_j(5'd3, 21'd8),                         32'd0,  32'd0, 32'd24, 0), // R7
    v(7, e_i(7'h67, 3'd0, 5'd3, 5'd1, 12'd0),      32'd29, 32'd0, 32'd24, 0),
    v(8, e_u(7'h37, 5'd3, 20'hABCDE),              32'd0,  32'd0, 32'hABCDE000, 1), // R8
    v(8, e_u(7'h17, 5'd3, 20'h00001),              32'd0,  32'd0, 32'h00001014, 1),
    v(9, e_i(7'h03, 3'd2, 5'd3, 5'd1, 12'd0),      32'd160, 32'd0, 32'hCAFEF00D, 1), // R9
    v(9, e_i(7'h03, 3'd2, 5'd3, 5'd1, 12'd0),      32'd162, 32'd0, 32'h55, 1),
    v(9, e_i(7'h03, 3'd2, 5'd3, 5'd1, 12'd0),      32'd256, 32'd0, 32'h55, 1),
    v(9, e_i(7'h03, 3'd0, 5'd3, 5'd1, 12'd0),      32'd160, 32'd0, 32'h55, 1)
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          ecall_valid;
  logic          ecall_ready = 1'b0;
  logic [31:0]   ecall_svc, ecall_arg, pc_o;
  logic          halted;

  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   mem [MW];
  logic [31:0]   img [MW];
  int            nchk = 0;
  int            nfail = 0;
  int            cyc = 0;
  int            req_cnt = 0;

  always #5 clk = ~clk;

  rvmc_core #(.MEM_WORDS(MW), .NREG(32)) u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ecall_valid(ecall_valid), .ecall_ready(ecall_ready),
    .ecall_svc(ecall_svc), .ecall_arg(ecall_arg), .pc_o(pc_o), .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (ecall_valid && ecall_ready) req_cnt <= req_cnt + 1;
    cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run did not finish act=%0d exp<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] hi20(input logic [31:0] x);
    logic [31:0] t;
    t = x + 32'h800;
    return t[31:12];
  endfunction

  task automatic clear_img();
    for (int i = 0; i < MW; i++) img[i] = 32'h0;
  endtask

  task automatic push_img();
    rst_n = 1'b0;
    step_en = 1'b0;
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_addr = AW'(i);
      ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_halt(input string tag);
    int n;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) chk(tag, 32'h0, 32'h1);
  endtask

  task automatic run_img(input string tag);
    push_img();
    rst_n = 1'b1;
    step_en = 1'b1;
    wait_halt(tag);
  endtask

  initial begin
    logic [31:0] pc_hold;
    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 halted", {31'h0, halted}, 32'h0);
    chk("R1 valid", {31'h0, ecall_valid}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [7:0]  rq;
      logic [31:0] ins, a, b, e3, e4;
      string       tg;
      {rq, ins, a, b, e3, e4} = VEC[k];
      tg = $sformatf("R%0d vec%0d", rq, k);
      clear_img();
      img[0] = e_u(7'h37, 5'd1, hi20(a));
      img[1] = e_i(7'h13, 3'd0, 5'd1, 5'd1, a[11:0]);
      img[2] = e_u(7'h37, 5'd2, hi20(b));
      img[3] = e_i(7'h13, 3'd0, 5'd2, 5'd2, b[11:0]);
      img[4] = e_i(7'h13, 3'd0, 5'd3, 5'd0, 12'h055);
      img[5] = ins;
      img[6] = e_i(7'h13, 3'd0, 5'd4, 5'd0, 12'd1);
      img[7] = e_s(5'd0, 5'd3, 12'd128);
      img[8] = e_s(5'd0, 5'd4, 12'd132);
      img[40] = 32'hCAFEF00D;
      img[32] = 32'hBAD0BAD0;
      img[33] = 32'hBAD0BAD0;
      run_img(tg);
      chk({tg, " x3"}, mem[32], e3);
      chk({tg, " x4 (R1 clear)"}, mem[33], e4);
      chk({tg, " R3 stop at zero word"}, pc_o, 32'd36);
    end

    // R12 step_en low keeps the core idle
    clear_img();
    img[0] = e_i(7'h13, 3'd0, 5'd6, 5'd0, 12'd7);
    img[1] = e_s(5'd0, 5'd6, 12'd128);
    push_img();
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R12 idle pc", pc_o, 32'h0);
    chk("R12 idle mem", mem[32], 32'h0);
    step_en = 1'b1;
    wait_halt("R12 resume");
    chk("R12 resumed store", mem[32], 32'd7);
    // R3 halt is permanent
    pc_hold = pc_o;
    repeat (20) @(negedge clk);
    chk("R3 pc frozen", pc_o, pc_hold);
    chk("R3 still halted", {31'h0, halted}, 32'h1);

    // R2 misaligned target, R7 jalr clears bit 0 (5 + 2 = 7 -> 6)
    clear_img();
    img[0] = e_i(7'h13, 3'd0, 5'd1, 5'd0, 12'd5);
    img[1] = e_i(7'h67, 3'd0, 5'd0, 5'd1, 12'd2);
    run_img("R2 misaligned");
    chk("R2 R7 misaligned pc", pc_o, 32'd6);

    // R2 forward past the end: word 64 must not alias word 0
    clear_img();
    img[0] = e_j(5'd0, 21'd256);
    run_img("R2 range");
    chk("R2 out of range pc", pc_o, 32'd256);

    // R7 backward jump sign-extends and wraps
    clear_img();
    img[0] = e_j(5'd0, 21'h1FFFFC);
    run_img("R7 back");
    chk("R7 negative jal", pc_o, 32'hFFFFFFFC);

    // R6 backward branch sign-extends from bit 12
    clear_img();
    img[0] = e_b(3'd0, 5'd0, 5'd0, 13'h1FF8);
    run_img("R6 back");
    chk("R6 negative branch", pc_o, 32'hFFFFFFF8);

    // R9 store guards and R10 x0
    clear_img();
    img[0] = e_i(7'h13, 3'd0, 5'd1, 5'd0, 12'h081);
    img[1] = e_i(7'h13, 3'd0, 5'd2, 5'd0, 12'h077);
    img[2] = e_s(5'd1, 5'd2, 12'd0);
    img[3] = e_s(5'd0, 5'd2, 12'd256);
    img[4] = e_s(5'd0, 5'd2, 12'd132);
    img[5] = e_i(7'h13, 3'd0, 5'd0, 5'd0, 12'd5);
    img[6] = e_s(5'd0, 5'd0, 12'd136);
    img[7] = e_i(7'h03, 3'd2, 5'd5, 5'd1, 12'd0);
    img[8] = e_s(5'd0, 5'd5, 12'd140);
    img[32] = 32'h00001111;
    img[34] = 32'h0000DEAD;
    img[35] = 32'h00009999;
    run_img("R9 store");
    chk("R9 misaligned store skipped", mem[32], 32'h00001111);
    chk("R9 out of range store skipped", mem[0], e_i(7'h13, 3'd0, 5'd1, 5'd0, 12'h081));
    chk("R9 aligned store", mem[33], 32'h77);
    chk("R10 x0 reads zero", mem[34], 32'h0);
    chk("R9 misaligned load skipped", mem[35], 32'h0);
    chk("R9 pc advanced", pc_o, 32'd36);

    // R11 console handshake
    clear_img();
    img[0] = e_i(7'h13, 3'd0, 5'd17, 5'd0, 12'd2);
    img[1] = e_i(7'h13, 3'd0, 5'd10, 5'd0, 12'h041);
    img[2] = 32'h00000073;
    img[3] = 32'h00001073;
    push_img();
    req_cnt = 0;
    rst_n = 1'b1;
    step_en = 1'b1;
    for (int n = 0; n < 200 && !ecall_valid; n++) @(negedge clk);
    chk("R11 request raised", {31'h0, ecall_valid}, 32'h1);
    chk("R11 service", ecall_svc, 32'd2);
    chk("R11 argument", ecall_arg, 32'h41);
    repeat (5) @(negedge clk);
    chk("R11 still waiting", {31'h0, ecall_valid}, 32'h1);
    chk("R11 pc held", pc_o, 32'd8);
    ecall_ready = 1'b1;
    @(negedge clk);
    ecall_ready = 1'b0;
    chk("R11 released", {31'h0, ecall_valid}, 32'h0);
    chk("R11 pc advanced", pc_o, 32'd12);
    wait_halt("R11 tail");
    chk("R11 other funct3 no request", req_cnt, 32'd1);
    chk("R11 final pc", pc_o, 32'd16);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule